// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives the six gate signals of a three-phase bridge (a high-side and a low-side switch for each of phases A, B and C). A 16-bit timer counts up to a programmed period and back down, and each phase compares it against its own duty value. The result is a pulse centred on the turning point of the count. Before the pulse reaches a pin, the block deletes pulses that are too short, can swap a phase's high and low side, delays every turn-on edge by a programmed dead time, and can disable single outputs or chop them with a fixed-rate carrier. A sync pulse of programmable width marks the start of every period.

Software programs the block through a write-only register port. Period, dead time, minimum pulse, sync width and the three duty values are held in staging registers. They move into the working set at the start of each period. In double-update mode the duty values also move at the turning point, so the rising half and the falling half of a period can use different duties. The control word is used as soon as it is written.

Top module: `pwm3_gen`

## Requirements
- R1: In the cycle after reset is released, all six gate outputs and the sync output are low. The control word (address 7) resets to 0x03F0, so all six outputs start disabled, and every other register resets to zero.
- R2: Register map: 0 = period P, 1 = dead time T, 2 = minimum pulse M, 3 = sync width W, 4/5/6 = duty of phase A/B/C. The control word at 7 has these fields: bit 0 selects double update, bits 3:1 are crossover for A/B/C, bits 6:4 disable the high outputs A/B/C, bits 9:7 disable the low outputs A/B/C, bit 10 enables high-side chopping and bit 11 enables low-side chopping. With T=0, M=0 and a duty D below P, a high output is on for 2·D cycles of each period and its low output is on for the other 2·(P−D) cycles.
- R3: The timer counts up over P cycles and down over P cycles, so one PWM period lasts 2·P clock cycles.
- R4: The sync output rises in the first cycle of each period and stays high for W+1 cycles.
- R5: Every turn-on edge of a gate output is delayed by 2·T cycles, so each pulse loses 2·T cycles. The high and low outputs of one phase are never on in the same cycle.
- R6: If the duty (limited to P) is below M, the high output stays off for the whole period. If P minus that duty is below M, the high output stays on for the whole period.
- R7: In single-update mode, a duty written during a period has no effect until the next period starts.
- R8: In double-update mode, a duty written during the first half of a period takes effect in the second half of that same period.
- R9: A set crossover bit swaps the on-times of that phase's high and low outputs.
- R10: A set disable bit forces its output low from the next cycle onward, without changing any other output.
- R11: When a side's chop enable is set, the outputs of that side are gated by a carrier that is on for 4 of every 8 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| gate_hi | output | 3 | High-side gate drives, phases A..C |
| gate_lo | output | 3 | Low-side gate drives, phases A..C |
| sync_out | output | 1 | Period-start pulse |

## Verification
Pulse deletion and dead time both act on the same pulse. Deletion decides whether the pulse exists at all, and dead time then trims the turn-on edge of whatever pulse is left. The bench sets a nonzero dead time and places the duty just above, then just below, the minimum pulse, and also near the top of the period. The kept pulse must come out exactly 2·T cycles short, while a deleted pulse must leave the opposite output on for the whole period with no dead-time gap at all.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int NPH = 3;
  localparam logic [2:0] A_PER   = 3'd0;
  localparam logic [2:0] A_DEAD  = 3'd1;
  localparam logic [2:0] A_MINP  = 3'd2;
  localparam logic [2:0] A_SYNCW = 3'd3;
  localparam logic [2:0] A_DUTY0 = 3'd4;
  localparam logic [2:0] A_CTRL  = 3'd7;
  localparam int B_DBL  = 0;
  localparam int B_XOV  = 1;
  localparam int B_DISH = 4;
  localparam int B_DISL = 7;
  localparam int B_CHH  = 10;
  localparam int B_CHL  = 11;
  localparam logic [15:0] CTRL_RST = 16'h03F0;
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DTW = 10,
  parameter int SWW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [2:0]               wr_addr,
  input  logic [CW-1:0]            wr_data,
  output logic [CW-1:0]            st_per,
  output logic [DTW-1:0]           st_dt,
  output logic [CW-1:0]            st_minp,
  output logic [SWW-1:0]           st_syncw,
  output logic [NPH-1:0][CW-1:0]   st_duty,
  output logic [15:0]              ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_per   <= '0;
      st_dt    <= '0;
      st_minp  <= '0;
      st_syncw <= '0;
      st_duty  <= '0;
      ctrl     <= CTRL_RST;
    end else if (wr_en) begin
      case (wr_addr)
        A_PER:   st_per   <= wr_data;
        A_DEAD:  st_dt    <= wr_data[DTW-1:0];
        A_MINP:  st_minp  <= wr_data;
        A_SYNCW: st_syncw <= wr_data[SWW-1:0];
        A_CTRL:  ctrl     <= wr_data[15:0];
        default: st_duty[wr_addr - A_DUTY0] <= wr_data;
      endcase
    end
  end
endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer
  import pwm3_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DTW = 10,
  parameter int SWW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     dbl,
  input  logic [CW-1:0]            st_per,
  input  logic [DTW-1:0]           st_dt,
  input  logic [CW-1:0]            st_minp,
  input  logic [SWW-1:0]           st_syncw,
  input  logic [NPH-1:0][CW-1:0]   st_duty,
  output logic [CW-1:0]            h_cnt,
  output logic                     dir_dn,
  output logic [CW-1:0]            act_per,
  output logic [DTW-1:0]           act_dt,
  output logic [CW-1:0]            act_minp,
  output logic [NPH-1:0][CW-1:0]   act_duty,
  output logic                     sync_q
);
  logic [CW:0]    h_inc;
  logic           mid_pt, end_pt;
  logic [SWW-1:0] s_left;

  assign h_inc  = {1'b0, h_cnt} + 1'b1;
  assign mid_pt = !dir_dn && (h_inc >= {1'b0, act_per});
  assign end_pt = dir_dn && (h_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt    <= '0;
      dir_dn   <= 1'b0;
      act_per  <= '0;
      act_dt   <= '0;
      act_minp <= '0;
      act_duty <= '0;
      s_left   <= '0;
      sync_q   <= 1'b0;
    end else begin
      if (end_pt) begin
        dir_dn   <= 1'b0;
        h_cnt    <= '0;
        act_per  <= st_per;
        act_dt   <= st_dt;
        act_minp <= st_minp;
        act_duty <= st_duty;
        s_left   <= st_syncw;
        sync_q   <= 1'b1;
      end else begin
        if (s_left != '0) begin
          s_left <= s_left - 1'b1;
          sync_q <= 1'b1;
        end else begin
          sync_q <= 1'b0;
        end
        if (mid_pt) begin
          dir_dn <= 1'b1;
          if (dbl) act_duty <= st_duty;
        end else if (dir_dn) begin
          h_cnt <= h_cnt - 1'b1;
        end else begin
          h_cnt <= h_inc[CW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/pwm3_dtgate.sv
module pwm3_dtgate #(
  parameter int DTW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           raw,
  input  logic [DTW-1:0] dt,
  output logic           gated
);
  localparam int DCW = DTW + 1;
  logic [DCW-1:0] need, run;

  assign need  = {dt, 1'b0};
  assign gated = raw && (run >= need);

  always_ff @(posedge clk) begin
    if (rst || !raw) run <= '0;
    else if (run < need) run <= run + 1'b1;
  end
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
  parameter int CW  = 16,
  parameter int DTW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CW-1:0]  h_cnt,
  input  logic [CW-1:0]  per,
  input  logic [CW-1:0]  duty,
  input  logic [CW-1:0]  minp,
  input  logic [DTW-1:0] dt,
  input  logic           xov,
  input  logic           dis_h,
  input  logic           dis_l,
  input  logic           chop,
  input  logic           chh_en,
  input  logic           chl_en,
  output logic           gh,
  output logic           gl
);
  logic [CW-1:0] sat, rest, eff;
  logic          on_q;
  logic [1:0]    raw, gated;

  always_comb begin
    sat  = (duty >= per) ? per : duty;
    rest = per - sat;
    if (sat < minp)       eff = '0;
    else if (rest < minp) eff = per;
    else                  eff = sat;
  end

  assign on_q   = ({1'b0, h_cnt} + {1'b0, eff}) >= {1'b0, per};
  assign raw[0] = xov ? !on_q : on_q;
  assign raw[1] = !raw[0];

  for (genvar s = 0; s < 2; s++) begin : g_side
    pwm3_dtgate #(.DTW(DTW)) u_dt (
      .clk(clk), .rst(rst), .raw(raw[s]), .dt(dt), .gated(gated[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gh <= 1'b0;
      gl <= 1'b0;
    end else begin
      gh <= gated[0] && !dis_h && (!chh_en || chop);
      gl <= gated[1] && !dis_l && (!chl_en || chop);
    end
  end
endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
  import pwm3_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DTW = 10,
  parameter int SWW = 8,
  parameter int CHW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [2:0]    gate_hi,
  output logic [2:0]    gate_lo,
  output logic          sync_out
);
  logic [CW-1:0]          st_per, st_minp, act_per, act_minp, h_cnt;
  logic [DTW-1:0]         st_dt, act_dt;
  logic [SWW-1:0]         st_syncw;
  logic [NPH-1:0][CW-1:0] st_duty, act_duty;
  logic [15:0]            ctrl;
  logic                   dir_dn;
  logic [NPH-1:0]         dis_h, dis_l, xov;
  logic [CHW-1:0]         cdiv;

  assign dis_h = ctrl[B_DISH +: NPH];
  assign dis_l = ctrl[B_DISL +: NPH];
  assign xov   = ctrl[B_XOV  +: NPH];

  always_ff @(posedge clk) begin
    if (rst) cdiv <= '0;
    else     cdiv <= cdiv + 1'b1;
  end

  pwm3_regs #(.CW(CW), .DTW(DTW), .SWW(SWW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .st_per(st_per), .st_dt(st_dt), .st_minp(st_minp), .st_syncw(st_syncw),
    .st_duty(st_duty), .ctrl(ctrl)
  );

  pwm3_timer #(.CW(CW), .DTW(DTW), .SWW(SWW)) u_timer (
    .clk(clk), .rst(rst), .dbl(ctrl[B_DBL]),
    .st_per(st_per), .st_dt(st_dt), .st_minp(st_minp), .st_syncw(st_syncw),
    .st_duty(st_duty), .h_cnt(h_cnt), .dir_dn(dir_dn), .act_per(act_per),
    .act_dt(act_dt), .act_minp(act_minp), .act_duty(act_duty), .sync_q(sync_out)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    pwm3_phase #(.CW(CW), .DTW(DTW)) u_ph (
      .clk(clk), .rst(rst), .h_cnt(h_cnt), .per(act_per), .duty(act_duty[p]),
      .minp(act_minp), .dt(act_dt), .xov(xov[p]), .dis_h(dis_h[p]),
      .dis_l(dis_l[p]), .chop(cdiv[CHW-1]), .chh_en(ctrl[B_CHH]),
      .chl_en(ctrl[B_CHL]), .gh(gate_hi[p]), .gl(gate_lo[p])
    );
  end
endmodule

// File: rtl/pwm3_chk.sv
module pwm3_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    gate_hi,
  input logic [2:0]    gate_lo,
  input logic          sync_out,
  input logic [CW-1:0] h_cnt,
  input logic          dir_dn,
  input logic [CW-1:0] act_per,
  input logic [2:0]    dis_h,
  input logic [2:0]    dis_l
);
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == 3'b000);

  p_sync_start_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_out) |-> (h_cnt == '0 && !dir_dn));

  p_count_range_r3: assert property (@(posedge clk) disable iff (rst)
    (act_per != '0) |-> (h_cnt < act_per));

  for (genvar i = 0; i < 3; i++) begin : g_seg
    p_seg_hi_r10: assert property (@(posedge clk) disable iff (rst)
      dis_h[i] |=> !gate_hi[i]);
    p_seg_lo_r10: assert property (@(posedge clk) disable iff (rst)
      dis_l[i] |=> !gate_lo[i]);
  end
endmodule

bind pwm3_gen pwm3_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .gate_hi(gate_hi), .gate_lo(gate_lo),
  .sync_out(sync_out), .h_cnt(h_cnt), .dir_dn(dir_dn), .act_per(act_per),
  .dis_h(dis_h), .dis_l(dis_l)
);

// File: tb/pwm3_gen_bench.sv
module pwm3_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  gate_hi, gate_lo;
  logic        sync_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  int hi_n [3];
  int lo_n [3];
  int ovl;
  localparam int P = 20;

  always #2 clk = ~clk;

  pwm3_gen u_pwm3_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .sync_out(sync_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int ctrl_word(int dbl, int xov, int dish, int disl, int chh, int chl);
    return dbl | (xov << 1) | (dish << 4) | (disl << 7) | (chh << 10) | (chl << 11);
  endfunction

  task automatic wait_sync();
    while (sync_out) @(negedge clk);
    while (!sync_out) @(negedge clk);
  endtask

  task automatic count_win(input int n);
    for (int p = 0; p < 3; p++) begin hi_n[p] = 0; lo_n[p] = 0; end
    ovl = 0;
    for (int k = 0; k < n; k++) begin
      for (int p = 0; p < 3; p++) begin
        hi_n[p] += int'(gate_hi[p]);
        lo_n[p] += int'(gate_lo[p]);
        if (gate_hi[p] && gate_lo[p]) ovl++;
      end
      @(negedge clk);
    end
  endtask

  task automatic settle_measure();
    wait_sync(); wait_sync(); wait_sync();
    count_win(2 * P);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "gate_hi after reset", int'(gate_hi), 0);
    check("R1", "gate_lo after reset", int'(gate_lo), 0);
    check("R1", "sync after reset", int'(sync_out), 0);
  endtask

  task automatic t_basic();
    wr(3'd0, P); wr(3'd1, 0); wr(3'd2, 0); wr(3'd3, 0);
    wr(3'd4, 5); wr(3'd5, 10); wr(3'd6, 15);
    wr(3'd7, ctrl_word(0, 0, 0, 0, 0, 0));
    settle_measure();
    check("R2", "hi A on-time", hi_n[0], 10);
    check("R2", "lo A on-time", lo_n[0], 30);
    check("R2", "hi B on-time", hi_n[1], 20);
    check("R2", "hi C on-time", hi_n[2], 30);
    check("R2", "lo C on-time", lo_n[2], 10);
  endtask

  task automatic t_period();
    int n = 0;
    wait_sync();
    @(negedge clk); n = 1;
    while (!(sync_out)) begin @(negedge clk); n++; end
    check("R3", "period length", n, 2 * P);
  endtask

  task automatic t_sync_width();
    int n = 0;
    wr(3'd3, 5);
    wait_sync(); wait_sync();
    while (sync_out) begin n++; @(negedge clk); end
    check("R4", "sync width", n, 6);
    wr(3'd3, 0);
  endtask

  task automatic t_dead();
    wr(3'd1, 3); wr(3'd4, 8);
    settle_measure();
    check("R5", "hi A with dead time", hi_n[0], 10);
    check("R5", "lo A with dead time", lo_n[0], 18);
    check("R5", "overlap cycles", ovl, 0);
    wr(3'd1, 0);
  endtask

  task automatic t_delete();
    wr(3'd1, 1); wr(3'd2, 4); wr(3'd4, 5);
    settle_measure();
    check("R6", "kept pulse hi A", hi_n[0], 8);
    check("R6", "kept pulse lo A", lo_n[0], 28);
    wr(3'd4, 3);
    settle_measure();
    check("R6", "deleted narrow hi A", hi_n[0], 0);
    check("R6", "lo A full period", lo_n[0], 40);
    wr(3'd4, 17);
    settle_measure();
    check("R6", "hi A full period", hi_n[0], 40);
    check("R6", "deleted narrow lo A", lo_n[0], 0);
    wr(3'd1, 0); wr(3'd2, 0);
  endtask

  task automatic t_update(input int dbl);
    wr(3'd7, ctrl_word(dbl, 0, 0, 0, 0, 0));
    wr(3'd4, 4);
    wait_sync(); wait_sync(); wait_sync();
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'd10;
    count_win(2 * P);
    wr_en = 1'b0;
    if (dbl != 0) begin
      check("R8", "double update mid reload", hi_n[0], 14);
    end else begin
      check("R7", "single update holds", hi_n[0], 8);
      count_win(2 * P);
      check("R7", "single update next period", hi_n[0], 20);
    end
  endtask

  task automatic t_cross();
    wr(3'd7, ctrl_word(0, 1, 0, 0, 0, 0));
    wr(3'd4, 5);
    settle_measure();
    check("R9", "crossover hi A", hi_n[0], 30);
    check("R9", "crossover lo A", lo_n[0], 10);
    check("R9", "no crossover hi B", hi_n[1], 20);
  endtask

  task automatic t_seg();
    wr(3'd7, ctrl_word(0, 0, 3'b010, 3'b000, 0, 0));
    settle_measure();
    check("R10", "disabled hi B", hi_n[1], 0);
    check("R10", "lo B untouched", lo_n[1], 20);
    check("R10", "hi A untouched", hi_n[0], 10);
  endtask

  task automatic t_chop();
    wr(3'd6, P);
    wr(3'd7, ctrl_word(0, 0, 0, 0, 1, 0));
    settle_measure();
    check("R11", "chopped full-on hi C", hi_n[2], 20);
    check("R11", "unchopped lo A", lo_n[0], 30);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_period();
    t_sync_width();
    t_dead();
    t_delete();
    t_update(0);
    t_update(1);
    t_cross();
    t_seg();
    t_chop();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule